// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Registered Status Flags

This block is the arithmetic and logic core of a small processor datapath. Two operands of `WIDTH` bits and a 3-bit operation code go in. A result comes out in the same cycle, through combinational logic only. The arithmetic operations share one ripple-carry adder, built from a chain of one-bit full-adder cells. The carry travels from each bit up to the next higher bit. The operand fed to the adder is inverted, zeroed or passed unchanged, and a carry-in is chosen to match the operation. The bitwise operations run in a separate logic unit. The operation code selects which of the two paths drives the result.

Five condition bits are derived from each result: zero, carry, negative, signed overflow and parity. A register captures all five on a rising clock edge when `flag_we` is high, and holds them otherwise. The next instruction or a sequencer can test or chain on the stored bits, for example by using the captured carry in a multi-word sum.

Top module: `alu_status_core`

## Requirements
- R1: Code 3'b000 (add) gives `result` = (A + B) mod 2^WIDTH, and the captured carry is the carry out of the top bit.
- R2: Code 3'b001 (subtract) gives `result` = A + ~B + 1 mod 2^WIDTH, and the captured carry is the adder's carry out (1 when A >= B unsigned).
- R3: For codes 3'b000 to 3'b010, the captured overflow bit is 1 exactly when the two's-complement result of the operation lies outside the signed WIDTH-bit range. For code 3'b011, both carry and overflow are 0.
- R4: Code 3'b010 (increment) gives `result` = (A + 1) mod 2^WIDTH, with carry 1 only when A is all ones.
- R5: Codes 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111 give A, A AND B, A OR B, A XOR B and NOT A in that order. For codes 3'b100 to 3'b111, the captured carry and overflow are 0.
- R6: The captured zero bit is 1 exactly when the result was all zeros.
- R7: The captured negative bit equals the top bit of the result.
- R8: The captured parity bit is 1 when the result holds an even number of 1 bits, and 0 when it holds an odd number.
- R9: The flags change only on a rising clock edge where `flag_we` is high. With `flag_we` low, they keep their value whatever the operands or code do.
- R10: A synchronous active-high `rst` clears all five flags on the next rising edge, even if `flag_we` is high.
- R11: `result` follows the operands and code within the same cycle, with no clock edge needed, whatever the value of `flag_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code |
| flag_we | input | 1 | Capture the new flags on this edge |
| result | output | WIDTH | Combinational result |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_n | output | 1 | Stored negative flag |
| flag_v | output | 1 | Stored signed-overflow flag |
| flag_p | output | 1 | Stored even-parity flag |

## Verification
Every operation code is run over every pair of 4-bit operands. This covers the cases that separate the flags:
- wrap to zero, where carry is set and zero is set;
- positive plus positive giving a negative value, where overflow is set and carry is clear;
- subtraction of the most negative value;
- increment of all ones;
- logic results that have the top bit set.

The write enable is dropped on a rotating subset of these cycles. This shows that the held flags belong to an older operation and not to the one currently on the inputs. A reset with the write enable high, taken while the flags are non-zero, separates a reset that takes priority from one that loses to the enable.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_INC  = 3'b010,
        OP_PASS = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_XOR  = 3'b110,
        OP_NOT  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic carry;
        logic neg;
        logic ovf;
        logic par;
    } alu_flags_t;

    typedef struct packed {
        logic invert_b;
        logic zero_b;
        logic carry_in;
    } adder_ctl_t;

    localparam alu_flags_t FLAGS_CLEAR = '{zero: 1'b0, carry: 1'b0, neg: 1'b0, ovf: 1'b0, par: 1'b0};

    function automatic logic is_logic_op(alu_op_e op);
        return op[2];
    endfunction

    function automatic adder_ctl_t decode_adder(alu_op_e op);
        adder_ctl_t ctl;
        ctl = '{invert_b: 1'b0, zero_b: 1'b0, carry_in: 1'b0};
        case (op)
            OP_ADD:  ctl = '{invert_b: 1'b0, zero_b: 1'b0, carry_in: 1'b0};
            OP_SUB:  ctl = '{invert_b: 1'b1, zero_b: 1'b0, carry_in: 1'b1};
            OP_INC:  ctl = '{invert_b: 1'b0, zero_b: 1'b1, carry_in: 1'b1};
            OP_PASS: ctl = '{invert_b: 1'b0, zero_b: 1'b1, carry_in: 1'b0};
            default: ctl = '{invert_b: 1'b0, zero_b: 1'b1, carry_in: 1'b0};
        endcase
        return ctl;
    endfunction

endpackage

// File: rtl/alu_fa_cell.sv
module alu_fa_cell (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half;

    assign half = x ^ y;
    assign s    = half ^ ci;
    assign co   = (x & y) | (ci & half);
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             c_into_msb
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        alu_fa_cell u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end

    assign cout       = chain[WIDTH];
    assign c_into_msb = chain[WIDTH-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_status_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
    import alu_status_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] res,
    input  logic             add_cout,
    input  logic             add_cmsb,
    output alu_flags_t       flags
);
    localparam int MSB = WIDTH - 1;

    alu_flags_t nxt;

    always_comb begin
        nxt.zero  = (res == '0);
        nxt.neg   = res[MSB];
        nxt.par   = ~^res;
        nxt.carry = is_logic_op(op) ? 1'b0 : add_cout;
        nxt.ovf   = is_logic_op(op) ? 1'b0 : (add_cout ^ add_cmsb);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= FLAGS_CLEAR;
        end else if (we) begin
            flags <= nxt;
        end
    end
endmodule

// File: rtl/alu_status_core.sv
module alu_status_core
    import alu_status_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    input  logic             flag_we,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_p
);
    alu_op_e          op;
    adder_ctl_t       actl;
    logic [WIDTH-1:0] b_cond;
    logic [WIDTH-1:0] add_sum;
    logic [WIDTH-1:0] lu_y;
    logic             add_cout;
    logic             add_cmsb;
    alu_flags_t       flags;

    assign op   = alu_op_e'(op_sel);
    assign actl = decode_adder(op);

    always_comb begin
        if (actl.zero_b)        b_cond = '0;
        else if (actl.invert_b) b_cond = ~opnd_b;
        else                    b_cond = opnd_b;
    end

    alu_ripple_adder #(.WIDTH(WIDTH)) u_add (
        .x          (opnd_a),
        .y          (b_cond),
        .cin        (actl.carry_in),
        .sum        (add_sum),
        .cout       (add_cout),
        .c_into_msb (add_cmsb)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_lu (
        .a  (opnd_a),
        .b  (opnd_b),
        .op (op),
        .y  (lu_y)
    );

    assign result = is_logic_op(op) ? lu_y : add_sum;

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .we       (flag_we),
        .op       (op),
        .res      (result),
        .add_cout (add_cout),
        .add_cmsb (add_cmsb),
        .flags    (flags)
    );

    assign flag_z = flags.zero;
    assign flag_c = flags.carry;
    assign flag_n = flags.neg;
    assign flag_v = flags.ovf;
    assign flag_p = flags.par;
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       op_sel,
    input logic             flag_we,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_n,
    input logic             flag_v,
    input logic             flag_p
);
    logic [4:0] fl;
    assign fl = {flag_z, flag_c, flag_n, flag_v, flag_p};

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (fl == 5'b0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(fl));

    assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_z == ($past(result) == '0)));

    assert_sign_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_n == $past(result[WIDTH-1])));

    assert_parity_R8: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (flag_p == ~^$past(result)));

    assert_logic_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_sel[2]) |=> (!flag_c && !flag_v));

    always_comb begin
        if (!rst && op_sel == 3'b000)
            assert_add_R1: assert (result == WIDTH'(opnd_a + opnd_b));
        if (!rst && op_sel == 3'b110)
            assert_xor_R5: assert (result == (opnd_a ^ opnd_b));
    end
endmodule

bind alu_status_core alu_status_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_alu_status_core.sv
module sim_alu_status_core;
    localparam int W    = 4;
    localparam int SPAN = 1 << W;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = 3'b000;
    logic         we = 1'b0;
    logic [W-1:0] result;
    logic         fz, fc, fn, fv, fp;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    alu_status_core #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .opnd_a(a), .opnd_b(b), .op_sel(op),
        .flag_we(we), .result(result),
        .flag_z(fz), .flag_c(fc), .flag_n(fn), .flag_v(fv), .flag_p(fp)
    );

    // model state: {z, c, n, v, p}
    int m_z = 0, m_c = 0, m_n = 0, m_v = 0, m_p = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v >= SPAN / 2) ? v - SPAN : v;
    endfunction

    task automatic model(input int o, input int x, input int y,
                         output int r, output int c, output int v);
        int full, sv;
        full = 0; sv = 0; c = 0; v = 0;
        case (o)
            0: begin full = x + y;                    sv = sgn(x) + sgn(y); end
            1: begin full = x + ((~y) & (SPAN-1)) + 1; sv = sgn(x) - sgn(y); end
            2: begin full = x + 1;                    sv = sgn(x) + 1;      end
            3: begin full = x;                        sv = sgn(x);          end
            4: full = x & y;
            5: full = x | y;
            6: full = x ^ y;
            default: full = (~x) & (SPAN-1);
        endcase
        r = full & (SPAN-1);
        if (o < 4) begin
            c = (full >> W) & 1;
            v = (sv > SPAN/2 - 1 || sv < -(SPAN/2)) ? 1 : 0;
        end
    endtask

    function automatic string op_tag(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_flags(input string sfx);
        chk({"R6 zero", sfx}, fz, m_z);
        chk({"R1/R2/R4/R5 carry", sfx}, fc, m_c);
        chk({"R7 neg", sfx}, fn, m_n);
        chk({"R3 ovf", sfx}, fv, m_v);
        chk({"R8 parity", sfx}, fp, m_p);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        string sfx;
        int r, c, v, ones, last_we;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_flags(" R10 after reset");
        rst = 1'b0;
        last_we = 1;

        for (int o = 0; o < 8; o++) begin
            for (int x = 0; x < SPAN; x++) begin
                for (int y = 0; y < SPAN; y++) begin
                    @(negedge clk);
                    sfx = (last_we != 0) ? "" : " R9 hold";
                    check_flags(sfx);
                    a  = W'(x);
                    b  = W'(y);
                    op = 3'(o);
                    we = ((x + y + o) % 4) != 0;
                    #1;
                    model(o, x, y, r, c, v);
                    chk({op_tag(o), " R11 result"}, int'(result), r);
                    @(posedge clk);
                    if (we) begin
                        ones = $countones(W'(r));
                        m_z = (r == 0) ? 1 : 0;
                        m_c = c;
                        m_n = (r >> (W-1)) & 1;
                        m_v = v;
                        m_p = (ones % 2 == 0) ? 1 : 0;
                    end
                    last_we = we ? 1 : 0;
                end
            end
        end

        // drive flags to a non-zero state, then reset with write enable high
        @(negedge clk);
        a = 4'b0111; b = 4'b0001; op = 3'b000; we = 1'b1;
        @(negedge clk);
        chk("R3 ovf set", fv, 1);
        chk("R7 neg set", fn, 1);
        rst = 1'b1;
        a = 4'b0000; b = 4'b0000; op = 3'b111;
        @(negedge clk);
        m_z = 0; m_c = 0; m_n = 0; m_v = 0; m_p = 0;
        check_flags(" R10 reset beats we");
        rst = 1'b0;
        we = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule